// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the slave-side command logic of a serial flash device for erase requests. It oversamples the serial clock, chip select and data input in the system clock domain, takes one data bit on every rising serial clock while chip select is low, and counts the bits in the frame. When chip select goes high it decides whether the frame was an exactly framed write-enable, sector erase or chip erase command. Serial clock idle low and idle high (SPI modes 0 and 3) are both accepted.

A legal erase is committed only if the write-enable latch is set, the device is idle and the target is not protected. Protection comes in as a per-region mask. On commit the block pulses a start strobe, presents the sector index or a whole-chip flag, and holds busy high for a self-timed duration in system clock cycles. Busy and the write-enable latch are the status bits it reports. Commands that fail any check are dropped without any other response.

Top module: `spi_erase_ctrl`

## Requirements
- R1: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable latch (`wel`) when chip select rises.
- R2: A frame of exactly 32 bits whose first byte is 0x20, followed by a 24-bit address sent MSB first, requests a sector erase. The sector index on `erase_sector` is address bits 23 down to 12, and address bits 11 down to 0 have no effect.
- R3: A frame of exactly 8 bits carrying opcode 0x60 or 0xC7 requests a chip erase, and `erase_chip` is 1 with the start strobe.
- R4: Only the rising edge of chip select ends a frame. A frame of any other length, or with any other opcode, is dropped: no start, and `wel` unchanged.
- R5: An erase request arriving while `wel` is 0 does not start.
- R6: The protection region of a sector is the top log2(REGIONS) bits of its index (address bits 23..20 by default). A sector erase into a region whose `prot_mask` bit is 1 is rejected, a chip erase is rejected if any mask bit is 1, and a rejection clears `wel`.
- R7: `busy` rises together with `erase_start` and stays high for exactly SE_CYCLES (sector) or CE_CYCLES (chip) clock cycles. `wel` clears in the cycle `busy` falls.
- R8: While `busy` is 1, every command (write enable included) is ignored.
- R9: Input bits are sampled on rising serial clock edges with the clock idling either low or high between frames.
- R10: After reset `erase_start`, `busy` and `wel` are 0. `erase_start` is a one-cycle pulse seen after the third rising system clock edge following the rise of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in, MSB first |
| prot_mask | input | REGIONS | One protect bit per region |
| erase_start | output | 1 | One-cycle erase start strobe |
| erase_chip | output | 1 | Committed erase is whole-chip |
| erase_sector | output | ADDR_W-SECT_LSB | Sector index of committed sector erase |
| busy | output | 1 | Self-timed erase in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The hardest cases to reach are frames that arrive while an erase is still running, and frames that are one bit short or long. These show their effect only through a start that must not happen and a latch that must not move. The bench uses long erase durations so that a whole write-enable and a full sector frame fit inside a chip-erase busy window. It also sends 31-bit, 32-bit-with-short-opcode and 9-bit frames between a write enable and a valid erase, and it mixes both serial clock idle levels. A reference model tracks latch, busy and start state on every clock.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_WREN   = 2'd1,
    CMD_SECTOR = 2'd2,
    CMD_CHIP   = 2'd3
  } erase_cmd_e;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_SECTOR  = 8'h20;
  localparam logic [7:0] OP_CHIP_A  = 8'h60;
  localparam logic [7:0] OP_CHIP_B  = 8'hC7;
  localparam int         OPCODE_W   = 8;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic cs_rise,
  output logic cs_low,
  output logic si_q
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sck_sh, cs_sh, si_sh;
  logic         sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh <= '0;
      cs_sh  <= '1;
      si_sh  <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_sh <= {sck_sh[TOP-1:0], sck};
      cs_sh  <= {cs_sh[TOP-1:0], cs_n};
      si_sh  <= {si_sh[TOP-1:0], si};
      sck_d  <= sck_sh[TOP];
      cs_d   <= cs_sh[TOP];
    end
  end

  always_comb begin
    cs_low   = ~cs_sh[TOP];
    sck_rise = sck_sh[TOP] & ~sck_d & ~cs_sh[TOP];
    cs_rise  = cs_sh[TOP] & ~cs_d;
    si_q     = si_sh[TOP];
  end
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sck_rise,
  input  logic                        cs_rise,
  input  logic                        cs_low,
  input  logic                        si_q,
  output logic                        cmd_stb,
  output erase_cmd_e                  cmd_kind,
  output logic [ADDR_W-SECT_LSB-1:0]  cmd_sector
);
  localparam int SECT_W  = ADDR_W - SECT_LSB;
  localparam int FRAME_W = OPCODE_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(OPCODE_W);
  localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shreg_q, shreg_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic               shift_en;

  assign shift_en = cs_low & sck_rise;

  always_comb begin
    shreg_nx = shreg_q;
    cnt_nx   = cnt_q;
    if (!cs_low) begin
      cnt_nx = '0;
    end else if (shift_en) begin
      shreg_nx = {shreg_q[FRAME_W-2:0], si_q};
      if (cnt_q != CNT_SAT) cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (shift_en) shreg_q <= shreg_nx;
      cnt_q <= cnt_nx;
    end
  end

  always_comb begin
    cmd_kind = CMD_NONE;
    if (cnt_q == CNT_SHORT) begin
      if (shreg_q[OPCODE_W-1:0] == OP_WREN) cmd_kind = CMD_WREN;
      else if (shreg_q[OPCODE_W-1:0] == OP_CHIP_A ||
               shreg_q[OPCODE_W-1:0] == OP_CHIP_B) cmd_kind = CMD_CHIP;
    end else if (cnt_q == CNT_LONG) begin
      if (shreg_q[FRAME_W-1 -: OPCODE_W] == OP_SECTOR) cmd_kind = CMD_SECTOR;
    end
    cmd_stb    = cs_rise;
    cmd_sector = shreg_q[ADDR_W-1 -: SECT_W];
  end
endmodule

// File: rtl/erase_gate.sv
module erase_gate
  import flash_erase_pkg::*;
#(
  parameter int SECT_W    = 12,
  parameter int REGIONS   = 16,
  parameter int SE_CYCLES = 64,
  parameter int CE_CYCLES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_stb,
  input  erase_cmd_e         cmd_kind,
  input  logic [SECT_W-1:0]  cmd_sector,
  input  logic [REGIONS-1:0] prot_mask,
  output logic               erase_start,
  output logic               erase_chip,
  output logic [SECT_W-1:0]  erase_sector,
  output logic               busy,
  output logic               wel
);
  localparam int MAX_DUR = (SE_CYCLES > CE_CYCLES) ? SE_CYCLES : CE_CYCLES;
  localparam int TIM_W   = $clog2(MAX_DUR + 1);
  localparam int REG_W   = $clog2(REGIONS);
  localparam logic [TIM_W-1:0] SE_LOAD = TIM_W'(SE_CYCLES - 1);
  localparam logic [TIM_W-1:0] CE_LOAD = TIM_W'(CE_CYCLES - 1);

  logic              busy_q, busy_nx, wel_q, wel_nx, start_q, start_nx;
  logic              chip_q, chip_nx;
  logic [SECT_W-1:0] sect_q, sect_nx;
  logic [TIM_W-1:0]  tim_q, tim_nx;
  logic [REG_W-1:0]  region;
  logic              sect_ok, chip_ok;

  always_comb begin
    region  = REG_W'(cmd_sector >> (SECT_W - REG_W));
    sect_ok = wel_q & ~prot_mask[region];
    chip_ok = wel_q & (prot_mask == '0);
  end

  always_comb begin
    busy_nx  = busy_q;
    wel_nx   = wel_q;
    start_nx = 1'b0;
    chip_nx  = chip_q;
    sect_nx  = sect_q;
    tim_nx   = tim_q;
    if (busy_q) begin
      if (tim_q == '0) begin
        busy_nx = 1'b0;
        wel_nx  = 1'b0;
      end else begin
        tim_nx = tim_q - 1'b1;
      end
    end else if (cmd_stb) begin
      unique case (cmd_kind)
        CMD_WREN: wel_nx = 1'b1;
        CMD_SECTOR: begin
          if (sect_ok) begin
            start_nx = 1'b1;
            busy_nx  = 1'b1;
            chip_nx  = 1'b0;
            sect_nx  = cmd_sector;
            tim_nx   = SE_LOAD;
          end else begin
            wel_nx = 1'b0;
          end
        end
        CMD_CHIP: begin
          if (chip_ok) begin
            start_nx = 1'b1;
            busy_nx  = 1'b1;
            chip_nx  = 1'b1;
            sect_nx  = '0;
            tim_nx   = CE_LOAD;
          end else begin
            wel_nx = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wel_q   <= 1'b0;
      start_q <= 1'b0;
      chip_q  <= 1'b0;
      sect_q  <= '0;
      tim_q   <= '0;
    end else begin
      busy_q  <= busy_nx;
      wel_q   <= wel_nx;
      start_q <= start_nx;
      if (start_nx) begin
        chip_q <= chip_nx;
        sect_q <= sect_nx;
      end
      if (busy_q || start_nx) tim_q <= tim_nx;
    end
  end

  assign erase_start  = start_q;
  assign erase_chip   = chip_q;
  assign erase_sector = sect_q;
  assign busy         = busy_q;
  assign wel          = wel_q;
endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECT_LSB    = 12,
  parameter int REGIONS     = 16,
  parameter int SE_CYCLES   = 64,
  parameter int CE_CYCLES   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sck,
  input  logic                       cs_n,
  input  logic                       si,
  input  logic [REGIONS-1:0]         prot_mask,
  output logic                       erase_start,
  output logic                       erase_chip,
  output logic [ADDR_W-SECT_LSB-1:0] erase_sector,
  output logic                       busy,
  output logic                       wel
);
  localparam int SECT_W = ADDR_W - SECT_LSB;

  logic [1:0]        rst_sh;
  logic              rst_core_n;
  logic              sck_rise, cs_rise, cs_low, si_q;
  logic              cmd_stb;
  erase_cmd_e        cmd_kind;
  logic [SECT_W-1:0] cmd_sector;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_core_n = rst_sh[1];

  spi_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .sck(sck), .cs_n(cs_n), .si(si),
    .sck_rise(sck_rise), .cs_rise(cs_rise), .cs_low(cs_low), .si_q(si_q)
  );

  cmd_framer #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_framer (
    .clk(clk), .rst_n(rst_core_n), .sck_rise(sck_rise), .cs_rise(cs_rise),
    .cs_low(cs_low), .si_q(si_q), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind),
    .cmd_sector(cmd_sector)
  );

  erase_gate #(.SECT_W(SECT_W), .REGIONS(REGIONS), .SE_CYCLES(SE_CYCLES),
               .CE_CYCLES(CE_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_core_n), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind),
    .cmd_sector(cmd_sector), .prot_mask(prot_mask), .erase_start(erase_start),
    .erase_chip(erase_chip), .erase_sector(erase_sector), .busy(busy), .wel(wel)
  );
endmodule

// File: rtl/erase_ctrl_chk.sv
module erase_ctrl_chk #(
  parameter int SECT_W  = 12,
  parameter int REGIONS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [REGIONS-1:0] prot_mask,
  input logic               erase_start,
  input logic               erase_chip,
  input logic [SECT_W-1:0]  erase_sector,
  input logic               busy,
  input logic               wel
);
  localparam int REG_W = $clog2(REGIONS);

  logic [REGIONS-1:0] prot_q;
  logic [REG_W-1:0]   start_region;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_q <= '0;
    else        prot_q <= prot_mask;
  end

  assign start_region = REG_W'(erase_sector >> (SECT_W - REG_W));

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(wel)); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !$past(busy)); // R8
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> busy); // R7
  AST_BUSY_ONLY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> erase_start); // R7
  AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R10
  AST_SECTOR_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && !erase_chip) |-> !prot_q[start_region]); // R6
  AST_CHIP_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && erase_chip) |-> (prot_q == '0)); // R6
endmodule

bind spi_erase_ctrl erase_ctrl_chk #(.SECT_W(SECT_W), .REGIONS(REGIONS)) u_chk (
  .clk(clk), .rst_n(rst_n), .prot_mask(prot_mask), .erase_start(erase_start),
  .erase_chip(erase_chip), .erase_sector(erase_sector), .busy(busy), .wel(wel)
);

// File: tb/spi_erase_ctrl_tb.sv
module spi_erase_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int SE_CYC     = 400;
  localparam int CE_CYC     = 1000;
  localparam int NREG       = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        si = 1'b0;
  logic [15:0] prot_mask = '0;
  logic        erase_start, erase_chip, busy, wel;
  logic [11:0] erase_sector;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int n_start = 0;
  int run_len = 0;
  int last_len = 0;
  bit done = 0;

  int ev_due[$];
  int ev_kind[$];
  int ev_sect[$];

  bit m_busy, m_wel, m_start, m_chip, ob, ow;
  int m_cnt, m_sect, k, s;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_erase_ctrl #(.SE_CYCLES(SE_CYC), .CE_CYCLES(CE_CYC), .REGIONS(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .prot_mask(prot_mask), .erase_start(erase_start), .erase_chip(erase_chip),
    .erase_sector(erase_sector), .busy(busy), .wel(wel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model, one step per clock
  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wel = 0; m_cnt = 0; m_start = 0;
    end else begin
      ob = m_busy; ow = m_wel; m_start = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin m_busy = 0; m_wel = 0; end
        else m_cnt--;
      end
      while (ev_due.size() > 0 && ev_due[0] == cyc) begin
        void'(ev_due.pop_front());
        k = ev_kind.pop_front();
        s = ev_sect.pop_front();
        if (!ob) begin
          if (k == 1) m_wel = 1;
          else if (k == 2) begin
            if (ow && !prot_mask[s >> 8]) begin
              m_start = 1; m_busy = 1; m_chip = 0; m_sect = s; m_cnt = SE_CYC - 1;
            end else m_wel = 0;
          end else if (k == 3) begin
            if (ow && prot_mask == 0) begin
              m_start = 1; m_busy = 1; m_chip = 1; m_cnt = CE_CYC - 1;
            end else m_wel = 0;
          end
        end
      end
      chk("R10 erase_start", int'(erase_start), int'(m_start));
      chk("R7 busy", int'(busy), int'(m_busy));
      chk("R1 wel", int'(wel), int'(m_wel));
      if (m_start) begin
        chk("R3 erase_chip", int'(erase_chip), int'(m_chip));
        if (!m_chip) chk("R2 erase_sector", int'(erase_sector), m_sect);
      end
    end
  end

  always @(negedge clk) begin
    if (erase_start) n_start++;
    if (busy) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
  end

  task automatic spi_cmd(input logic [31:0] w, input int n, input bit m3);
    int kind = 0;
    int sect = 0;
    @(negedge clk);
    sck = m3;
    repeat (HALF) @(negedge clk);
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sck = 0; si = w[n-1-i];
      repeat (HALF) @(negedge clk);
      sck = 1;
      repeat (HALF) @(negedge clk);
    end
    if (!m3) sck = 0;
    repeat (HALF) @(negedge clk);
    if (n == 8 && w[7:0] == 8'h06) kind = 1;
    else if (n == 8 && (w[7:0] == 8'h60 || w[7:0] == 8'hC7)) kind = 3;
    else if (n == 32 && w[31:24] == 8'h20) begin kind = 2; sect = int'(w[23:12]); end
    cs_n = 1;
    ev_due.push_back(cyc + 3);
    ev_kind.push_back(kind);
    ev_sect.push_back(sect);
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_busy || ev_due.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk("R10 reset erase_start", int'(erase_start), 0);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset wel", int'(wel), 0);
    rst_n = 1;
    repeat (6) @(negedge clk);

    // R1 and R2, mode 0, low address bits set
    spi_cmd(32'h06, 8, 0);
    chk("R1 wel after write enable", int'(wel), 1);
    base = n_start;
    spi_cmd(32'h20123ABC, 32, 0);
    wait_idle();
    chk("R10 one start pulse", n_start - base, 1);
    chk("R2 sector index", int'(erase_sector), 12'h123);
    chk("R7 sector busy length", last_len, SE_CYC);
    chk("R7 wel cleared after erase", int'(wel), 0);

    // R9 and R3, mode 3, chip erase opcode 0x60
    spi_cmd(32'h06, 8, 1);
    base = n_start;
    spi_cmd(32'h60, 8, 1);
    wait_idle();
    chk("R9 mode 3 start", n_start - base, 1);
    chk("R3 chip flag", int'(erase_chip), 1);
    chk("R7 chip busy length", last_len, CE_CYC);

    // R5: erase without latch
    base = n_start;
    spi_cmd(32'hC7, 8, 0);
    spi_cmd(32'h20000000, 32, 1);
    wait_idle();
    chk("R5 no start without wel", n_start - base, 0);

    // R4: mis-framed commands leave latch set
    spi_cmd(32'h06, 8, 0);
    base = n_start;
    spi_cmd(32'h10246800, 31, 0);
    spi_cmd(32'h60000000, 32, 1);
    spi_cmd(32'h0C7, 9, 0);
    spi_cmd(32'h20123456, 33, 0);
    spi_cmd(32'h5A, 8, 1);
    wait_idle();
    chk("R4 no start on bad frame", n_start - base, 0);
    chk("R4 wel kept on bad frame", int'(wel), 1);

    // R6: protected region rejects and clears latch
    prot_mask = 16'h8000;
    spi_cmd(32'h20FFFFFF, 32, 0);
    wait_idle();
    chk("R6 protected sector rejected", n_start - base, 0);
    chk("R6 rejection clears wel", int'(wel), 0);
    spi_cmd(32'h06, 8, 1);
    spi_cmd(32'hC7, 8, 1);
    wait_idle();
    chk("R6 chip erase rejected", n_start - base, 0);
    chk("R6 chip rejection clears wel", int'(wel), 0);
    spi_cmd(32'h06, 8, 0);
    spi_cmd(32'h200FF000, 32, 0);
    wait_idle();
    chk("R6 unprotected sector starts", n_start - base, 1);
    chk("R2 sector index low region", int'(erase_sector), 12'h0FF);

    // R8: commands during busy are ignored
    prot_mask = '0;
    spi_cmd(32'h06, 8, 0);
    base = n_start;
    spi_cmd(32'hC7, 8, 0);
    spi_cmd(32'h06, 8, 1);
    spi_cmd(32'h20400000, 32, 1);
    chk("R8 still busy", int'(busy), 1);
    wait_idle();
    chk("R8 one start only", n_start - base, 1);
    chk("R8 wel clear after busy", int'(wel), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule